// File: doc/BRIEF.md
# PCI Parity Generator and Checker

This block sits beside the transfer state machine of a 32-bit PCI bus interface and handles all parity work on the bus. Every clock it folds the address/data lines and the command/byte-enable lines into one even-parity bit and presents it one clock later. It also raises an output enable for that bit, so the parity line follows the address/data drive pattern one clock behind. Whether the bit is driven depends on the interface's role (initiator or target), on whether the cycle is an address or a data phase, and on the transfer direction.

When the interface is the target of a write, the block checks the parity that the other agent sends. For each completed data phase it latches the expected parity, compares it with the parity line one clock later, and on a mismatch drives the parity-error line low and then high before it releases it. A local detection and an error reported by another device each set their own sticky status bit. Each bit can raise a level interrupt request. Per source, an enable and a routing select choose between the NMI-style and the SMI-style request line.

Top module: `pci_parity_unit`

## Requirements
- R1: `par_out` in cycle N+1 equals the XOR of all 32 `ad_in` bits and all 4 `cbe_n_in` bits of cycle N, whatever byte enables are active, so the 37 bits together hold an even number of ones.
- R2: `par_oe` is high in cycle N+1 exactly when, in cycle N, `addr_phase` was high with `is_initiator`=1, or `data_phase` was high with `is_initiator`=1 and `is_write`=1, or with `is_initiator`=0 and `is_write`=0.
- R3: Parity is never driven for a cycle in which the interface is the target (`is_initiator`=0) and the cycle is an address phase or a data phase of a write.
- R4: A check is armed only by a cycle with `data_phase`, `xfer_done` and `is_write` high and `is_initiator` low. The block then compares `par_in` of the next cycle with the parity of the arming cycle. A wrong `par_in` after any other cycle has no effect.
- R5: A failed check of a phase completed in cycle N drives `perr_oe`=1 with `perr_n_out`=0 in cycle N+2, and `perr_oe`=1 with `perr_n_out`=1 in cycle N+3. `perr_oe` is low in cycle N+4 unless a later failure keeps the line driven low. `perr_n_out` is 1 whenever it is not driving low.
- R6: A failed check sets `sts_det` in the same cycle that `perr_n_out` first goes low. `sts_det` stays set until it is cleared.
- R7: `perr_n_in` low in cycle M while `perr_oe` is low sets `sts_rcv` from cycle M+1 on, and the bit stays set. `perr_n_in` low while `perr_oe` is high is ignored.
- R8: A high `clr_det`/`clr_rcv` in cycle M clears the matching status bit in cycle M+1. A set in the same cycle wins over the clear.
- R9: `irq_nmi` is high whenever a status bit is set, its enable is 1 and its select is 0. `irq_smi` is the same with the select at 1. Both follow the status bits in the same cycle.
- R10: Synchronous active-low reset leaves `par_out`, `par_oe`, `perr_oe`, both status bits and both requests at 0, and `perr_n_out` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ad_in | input | 32 | Address/data lines as seen on the bus |
| cbe_n_in | input | 4 | Command/byte-enable lines (active low) |
| addr_phase | input | 1 | Current cycle is an address phase |
| data_phase | input | 1 | Current cycle belongs to a data phase |
| xfer_done | input | 1 | Data phase completes this cycle (both ready signals asserted) |
| is_initiator | input | 1 | 1 = interface is initiator, 0 = target |
| is_write | input | 1 | 1 = write transaction, 0 = read |
| par_in | input | 1 | Parity line as seen on the bus |
| perr_n_in | input | 1 | Parity-error line as seen on the bus (active low) |
| clr_det | input | 1 | Clear pulse for the detected-error status |
| clr_rcv | input | 1 | Clear pulse for the reported-error status |
| irq_en_det | input | 1 | Request enable for detected errors |
| irq_en_rcv | input | 1 | Request enable for reported errors |
| smi_sel_det | input | 1 | Route detected errors to SMI (1) or NMI (0) |
| smi_sel_rcv | input | 1 | Route reported errors to SMI (1) or NMI (0) |
| par_out | output | 1 | Generated parity, one clock late |
| par_oe | output | 1 | Output enable for `par_out` |
| perr_n_out | output | 1 | Parity-error drive value (active low) |
| perr_oe | output | 1 | Output enable for `perr_n_out` |
| sts_det | output | 1 | Sticky: parity error detected locally |
| sts_rcv | output | 1 | Sticky: parity error reported by another device |
| irq_nmi | output | 1 | NMI-style request |
| irq_smi | output | 1 | SMI-style request |

## Verification
The bench targets back-to-back failing write phases, where a design that ends the low pulse too early would drive the line high between two errors. It corrupts parity after initiator writes and target reads, which a design that checks in the wrong role would flag. It pulls the error input low while the block itself drives the line, which a design without the self-drive mask would log as a reported error. It also lines up a clear with a new detection in the same cycle, where the wrong priority loses the error. Byte-enable patterns that vary per cycle catch a generator that masks disabled lanes, and a one-cycle shift of the parity bit or its enable shows up on every compared cycle.

// File: rtl/pci_par_pkg.sv
// Shared definitions for the PCI parity block.
// Assumes an 8-bit lane per command/byte-enable bit.
package pci_par_pkg;
    typedef enum logic {
        ROLE_TGT  = 1'b0,
        ROLE_INIT = 1'b1
    } role_e;

    // Index of each sticky error source in the status array
    localparam int SRC_DET = 0;
    localparam int SRC_RCV = 1;
    localparam int NSRC    = 2;

    localparam int LANE_W  = 8;
endpackage

// File: rtl/par_tree.sv
// Parity tree: XOR of every data bit and every byte-enable bit.
// Each lane folds its data byte with its enable bit, and the lanes are then combined.
// Assumes DATA_W is a multiple of the lane width. Byte enables never mask a lane.
module par_tree
    import pci_par_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / LANE_W
) (
    input  logic [DATA_W-1:0] data,
    input  logic [LANES-1:0]  be_n,
    output logic              par
);
    logic [LANES-1:0] lane_par;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            // fold one byte lane with its enable bit
            assign lane_par[g] = (^data[g*LANE_W +: LANE_W]) ^ be_n[g];
        end
    endgenerate

    assign par = ^lane_par;
endmodule

// File: rtl/par_drive.sv
// Parity output path: registers the computed parity and the drive decision.
// Both reach the bus one clock after the phase they cover.
// Assumes the role and direction inputs are valid in every address and data phase.
module par_drive
    import pci_par_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic par_calc,
    input  logic addr_phase,
    input  logic data_phase,
    input  logic is_init,
    input  logic is_write,
    output logic par_out,
    output logic par_oe
);
    role_e role;
    logic  drive_data;
    logic  drive_now;

    // decode who owns the parity line this cycle
    always_comb begin
        role       = role_e'(is_init);
        drive_data = (role == ROLE_INIT) ? is_write : !is_write;
        drive_now  = (addr_phase && role == ROLE_INIT) || (data_phase && drive_data);
    end

    // delay parity and its enable by one clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_out <= 1'b0;
            par_oe  <= 1'b0;
        end else begin
            par_out <= par_calc;
            par_oe  <= drive_now;
        end
    end

    // R3
    tgt_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_init && (is_write || !data_phase)) |=> !par_oe);

    // R2
    init_addr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_phase && is_init) |=> par_oe);
endmodule

// File: rtl/par_check.sv
// Receive-side check: arms on a completed target-write data phase and compares
// par_in one clock later. It then drives the error line low for one clock and
// high for one clock before release. Assumes xfer_done is valid only in data phases.
module par_check (
    input  logic clk,
    input  logic rst_n,
    input  logic par_calc,
    input  logic par_in,
    input  logic data_phase,
    input  logic xfer_done,
    input  logic is_init,
    input  logic is_write,
    output logic err_evt,
    output logic perr_n_out,
    output logic perr_oe
);
    logic arm;
    logic pend;
    logic exp_par;
    logic drv_low;
    logic drv_high;

    // arm only on a completed data phase written to this target
    always_comb begin
        arm     = data_phase && xfer_done && !is_init && is_write;
        err_evt = pend && (par_in != exp_par);
    end

    // hold the expected parity and sequence the error drive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend     <= 1'b0;
            exp_par  <= 1'b0;
            drv_low  <= 1'b0;
            drv_high <= 1'b0;
        end else begin
            pend     <= arm;
            if (arm) exp_par <= par_calc;
            drv_low  <= err_evt;
            drv_high <= drv_low && !err_evt;
        end
    end

    assign perr_oe    = drv_low || drv_high;
    assign perr_n_out = !drv_low;

    // R5
    perr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_oe && !perr_n_out) |=> perr_oe);

    // R5
    perr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_oe && perr_n_out) |=> (!perr_oe || !perr_n_out));

    // R4
    low_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_oe && !perr_n_out) |-> $past(pend));
endmodule

// File: rtl/par_status.sv
// Sticky error status with write-one-to-clear pulses and NMI/SMI request routing.
// A set beats a clear in the same cycle. A reported error is ignored while this
// block drives the line itself.
module par_status
    import pci_par_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic det_set,
    input  logic perr_low_in,
    input  logic own_drive,
    input  logic clr_det,
    input  logic clr_rcv,
    input  logic en_det,
    input  logic en_rcv,
    input  logic smi_det,
    input  logic smi_rcv,
    output logic sts_det,
    output logic sts_rcv,
    output logic irq_nmi,
    output logic irq_smi
);
    logic [NSRC-1:0] set_v;
    logic [NSRC-1:0] clr_v;
    logic [NSRC-1:0] en_v;
    logic [NSRC-1:0] smi_v;
    logic [NSRC-1:0] sts_q;
    logic [NSRC-1:0] req_nmi;
    logic [NSRC-1:0] req_smi;

    // gather per-source controls
    always_comb begin
        set_v[SRC_DET] = det_set;
        set_v[SRC_RCV] = perr_low_in && !own_drive;
        clr_v = {clr_rcv, clr_det};
        en_v  = {en_rcv, en_det};
        smi_v = {smi_rcv, smi_det};
    end

    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_src
            // sticky bit: set has priority over clear
            always_ff @(posedge clk) begin
                if (!rst_n)        sts_q[g] <= 1'b0;
                else if (set_v[g]) sts_q[g] <= 1'b1;
                else if (clr_v[g]) sts_q[g] <= 1'b0;
            end

            assign req_nmi[g] = sts_q[g] && en_v[g] && !smi_v[g];
            assign req_smi[g] = sts_q[g] && en_v[g] &&  smi_v[g];

            // R6 R7
            sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (sts_q[g] && !clr_v[g]) |=> sts_q[g]);

            // R8
            set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                set_v[g] |=> sts_q[g]);
        end
    endgenerate

    assign sts_det = sts_q[SRC_DET];
    assign sts_rcv = sts_q[SRC_RCV];
    assign irq_nmi = |req_nmi;
    assign irq_smi = |req_smi;

    // R9
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_nmi || irq_smi) |-> (sts_det || sts_rcv));
endmodule

// File: rtl/pci_parity_unit.sv
// Top of the PCI parity block. One parity tree feeds the output path and the
// receive checker, and the checker's error event and the bus error line feed the status.
// Assumes phase, role and direction come from the bus transfer state machine.
module pci_parity_unit #(
    parameter int DATA_W = 32,
    localparam int BE_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] ad_in,
    input  logic [BE_W-1:0]   cbe_n_in,
    input  logic              addr_phase,
    input  logic              data_phase,
    input  logic              xfer_done,
    input  logic              is_initiator,
    input  logic              is_write,
    input  logic              par_in,
    input  logic              perr_n_in,
    input  logic              clr_det,
    input  logic              clr_rcv,
    input  logic              irq_en_det,
    input  logic              irq_en_rcv,
    input  logic              smi_sel_det,
    input  logic              smi_sel_rcv,
    output logic              par_out,
    output logic              par_oe,
    output logic              perr_n_out,
    output logic              perr_oe,
    output logic              sts_det,
    output logic              sts_rcv,
    output logic              irq_nmi,
    output logic              irq_smi
);
    logic par_calc;
    logic err_evt;

    par_tree #(.DATA_W(DATA_W)) u_tree (
        .data (ad_in),
        .be_n (cbe_n_in),
        .par  (par_calc)
    );

    par_drive u_drive (
        .clk        (clk),
        .rst_n      (rst_n),
        .par_calc   (par_calc),
        .addr_phase (addr_phase),
        .data_phase (data_phase),
        .is_init    (is_initiator),
        .is_write   (is_write),
        .par_out    (par_out),
        .par_oe     (par_oe)
    );

    par_check u_check (
        .clk        (clk),
        .rst_n      (rst_n),
        .par_calc   (par_calc),
        .par_in     (par_in),
        .data_phase (data_phase),
        .xfer_done  (xfer_done),
        .is_init    (is_initiator),
        .is_write   (is_write),
        .err_evt    (err_evt),
        .perr_n_out (perr_n_out),
        .perr_oe    (perr_oe)
    );

    par_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .det_set     (err_evt),
        .perr_low_in (!perr_n_in),
        .own_drive   (perr_oe),
        .clr_det     (clr_det),
        .clr_rcv     (clr_rcv),
        .en_det      (irq_en_det),
        .en_rcv      (irq_en_rcv),
        .smi_det     (smi_sel_det),
        .smi_rcv     (smi_sel_rcv),
        .sts_det     (sts_det),
        .sts_rcv     (sts_rcv),
        .irq_nmi     (irq_nmi),
        .irq_smi     (irq_smi)
    );

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!par_oe && !perr_oe && perr_n_out && !sts_det && !sts_rcv));
endmodule

// File: tb/sim_pci_parity_unit.sv
module sim_pci_parity_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ad_in = '0;
    logic [3:0]  cbe_n_in = '0;
    logic addr_phase = 0, data_phase = 0, xfer_done = 0, is_initiator = 0, is_write = 0;
    logic par_in = 0, perr_n_in = 1, clr_det = 0, clr_rcv = 0;
    logic irq_en_det = 0, irq_en_rcv = 0, smi_sel_det = 0, smi_sel_rcv = 0;
    logic par_out, par_oe, perr_n_out, perr_oe, sts_det, sts_rcv, irq_nmi, irq_smi;

    always #5 clk = ~clk;

    pci_parity_unit u0 (.*);

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // behavioural reference state
    bit m_par, m_oe, m_pend, m_exp, m_det, m_rcv, m_err, m_now_oe;
    int lows[$];
    // bench-side memory of the parity owed by the other agent
    bit owe_valid, owe_par;

    function automatic bit is_low(int c);
        foreach (lows[i]) if (lows[i] == c) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit exp_oe(int c);
        return is_low(c) || is_low(c - 1);
    endfunction

    // reference model, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_par = 0; m_oe = 0; m_pend = 0; m_exp = 0; m_det = 0; m_rcv = 0;
            lows.delete();
        end else begin
            m_now_oe = exp_oe(cyc);
            m_err = m_pend && (par_in != m_exp);
            if (m_err) m_det = 1; else if (clr_det) m_det = 0;
            if (!perr_n_in && !m_now_oe) m_rcv = 1; else if (clr_rcv) m_rcv = 0;
            if (m_err) lows.push_back(cyc + 1);
            while (lows.size() > 0 && lows[0] < cyc - 4) void'(lows.pop_front());
            m_par = ^{ad_in, cbe_n_in};
            m_oe  = (addr_phase && is_initiator) ||
                    (data_phase && ((is_initiator && is_write) || (!is_initiator && !is_write)));
            m_pend = data_phase && xfer_done && !is_initiator && is_write;
            if (m_pend) m_exp = ^{ad_in, cbe_n_in};
        end
        cyc++;
    end

    task automatic chk(string req, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", req, what, cyc, act, exp);
        end
    endtask

    // compare every output against the model
    task automatic compare_all();
        bit lo, en;
        lo = is_low(cyc);
        en = exp_oe(cyc);
        chk("R1", "par_out", par_out, m_par);
        chk("R2", "par_oe", par_oe, m_oe);
        chk("R5", "perr_oe", perr_oe, en);
        chk("R5", "perr_n_out", perr_n_out, !lo);
        chk("R6", "sts_det", sts_det, m_det);
        chk("R7", "sts_rcv", sts_rcv, m_rcv);
        chk("R9", "irq_nmi", irq_nmi,
            (m_det && irq_en_det && !smi_sel_det) || (m_rcv && irq_en_rcv && !smi_sel_rcv));
        chk("R9", "irq_smi", irq_smi,
            (m_det && irq_en_det && smi_sel_det) || (m_rcv && irq_en_rcv && smi_sel_rcv));
    endtask

    // one cycle: compare current outputs, then apply inputs for this cycle
    task automatic go(bit a, bit d, bit x, bit init, bit wr, bit inj,
                      bit pin_n, bit cd, bit cr);
        @(negedge clk);
        if (rst_n) compare_all();
        ad_in = $urandom; cbe_n_in = 4'($urandom);
        addr_phase = a; data_phase = d; xfer_done = x;
        is_initiator = init; is_write = wr;
        perr_n_in = pin_n; clr_det = cd; clr_rcv = cr;
        par_in = owe_valid ? (owe_par ^ inj) : 1'($urandom);
        owe_valid = d && x && !init && wr;
        owe_par = ^{ad_in, cbe_n_in};
    endtask

    task automatic idle(bit inj);
        go(0, 0, 0, 0, 0, inj, 1, 0, 0);
    endtask

    // R1 R2 R3 directed: each role/direction with a known parity pattern
    task automatic drive_pattern(bit a, bit d, bit init, bit wr, bit exp_drive, string req);
        go(a, d, 1, init, wr, 0, 1, 0, 0);
        ad_in = 32'h0000_00FF; cbe_n_in = 4'b0001;
        owe_par = ^{ad_in, cbe_n_in};
        idle(0);
        chk(req, "pattern par_oe", par_oe, exp_drive);
        chk("R1", "pattern par_out", par_out, 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        owe_valid = 0; owe_par = 0;
        repeat (3) @(negedge clk);
        @(negedge clk);
        // R10 reset state
        chk("R10", "reset par_oe", par_oe, 1'b0);
        chk("R10", "reset perr_oe", perr_oe, 1'b0);
        chk("R10", "reset perr_n_out", perr_n_out, 1'b1);
        chk("R10", "reset sts_det", sts_det, 1'b0);
        chk("R10", "reset sts_rcv", sts_rcv, 1'b0);
        chk("R10", "reset irq", irq_nmi | irq_smi, 1'b0);
        rst_n = 1'b1;
        irq_en_det = 1; irq_en_rcv = 1;

        // R1 R2 R3: fixed patterns; 8 data ones plus one enable one gives odd count -> par 1
        drive_pattern(1, 0, 1, 0, 1'b1, "R2");
        drive_pattern(1, 0, 0, 1, 1'b0, "R3");
        drive_pattern(0, 1, 0, 1, 1'b0, "R3");
        drive_pattern(0, 1, 0, 0, 1'b1, "R2");
        drive_pattern(0, 1, 1, 1, 1'b1, "R2");

        // random clean traffic
        for (int i = 0; i < 400; i++)
            go(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
               0, 1, 0, 0);

        // R4: wrong parity after an initiator write and a target read -> no error
        go(0, 1, 1, 1, 1, 0, 1, 1, 0);
        go(0, 1, 1, 0, 0, 1, 1, 0, 0);
        par_in = !par_in;
        idle(0);
        par_in = !par_in;
        idle(0); idle(0);
        chk("R4", "no check outside target write", perr_oe, 1'b0);
        chk("R4", "no status outside target write", sts_det, 1'b0);

        // R5 R6: back-to-back failing target writes
        go(0, 1, 1, 0, 1, 0, 1, 0, 0);
        go(0, 1, 1, 0, 1, 1, 1, 0, 0);
        idle(1);
        chk("R5", "first low", !perr_n_out && perr_oe, 1'b1);
        chk("R6", "det set with low", sts_det, 1'b1);
        idle(0);
        chk("R5", "second low kept", !perr_n_out && perr_oe, 1'b1);
        idle(0);
        chk("R5", "high before release", perr_n_out && perr_oe, 1'b1);
        idle(0);
        chk("R5", "released", perr_oe, 1'b0);

        // R9 routing
        smi_sel_det = 0;
        idle(0);
        chk("R9", "det to nmi", irq_nmi, 1'b1);
        smi_sel_det = 1;
        idle(0);
        chk("R9", "det to smi", irq_smi && !irq_nmi, 1'b1);
        irq_en_det = 0;
        idle(0);
        chk("R9", "det masked", irq_smi, 1'b0);
        irq_en_det = 1;

        // R8: clear, then clear and set in the same cycle
        go(0, 0, 0, 0, 0, 0, 1, 1, 0);
        idle(0);
        chk("R8", "det cleared", sts_det, 1'b0);
        go(0, 1, 1, 0, 1, 0, 1, 0, 0);
        go(0, 0, 0, 0, 0, 1, 1, 1, 0);
        idle(0);
        chk("R8", "set beats clear", sts_det, 1'b1);

        // R7: reported error ignored while driving, logged when idle
        idle(0); idle(0);
        go(0, 0, 0, 0, 0, 0, 1, 0, 1);
        go(0, 1, 1, 0, 1, 0, 1, 0, 0);
        idle(1);
        go(0, 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R7", "own drive active", perr_oe, 1'b1);
        idle(0);
        chk("R7", "ignored while driving", sts_rcv, 1'b0);
        idle(0);
        go(0, 0, 0, 0, 0, 0, 0, 0, 0);
        idle(0);
        chk("R7", "reported error logged", sts_rcv, 1'b1);
        smi_sel_rcv = 1;
        idle(0);
        chk("R9", "rcv to smi", irq_smi, 1'b1);

        // random traffic with corruption, clears, reported errors and config changes
        for (int i = 0; i < 700; i++) begin
            if (i % 50 == 0) begin
                irq_en_det = 1'($urandom); irq_en_rcv = 1'($urandom);
                smi_sel_det = 1'($urandom); smi_sel_rcv = 1'($urandom);
            end
            go(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
               ($urandom % 4) == 0, ($urandom % 20) != 0,
               ($urandom % 10) == 0, ($urandom % 10) == 0);
        end
        idle(0); idle(0);
        @(negedge clk);
        compare_all();

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule